// File: doc/BRIEF.md
# Per-Channel Thermal Fault Protection Controller

This block owns the output enables of a group of switched output channels and shuts a channel down when its thermal comparators report trouble. Each channel watches two fault sources, both arriving as synchronous digital comparator flags. The first is a junction temperature above its shutdown limit. The second is a junction-to-case temperature difference above its power-limit threshold. When either one trips, the controller forces that channel off and records the event in one of two per-channel status registers. A global status byte and a global error flag summarise those registers.

Software switches channels on and off through a channel-on register. It picks the recovery policy for each channel through a restart-mode register. In auto-restart mode a channel comes back by itself once its recovery flag holds. In latched mode the channel also waits for a read-and-clear command on the matching status address. Every switch-on through the channel-on register opens a blanking window of `BLANK_CYCLES` clocks, during which power-limit events are ignored. Over-temperature events are never masked.

Each channel runs a five-state machine. The states are `ST_OFF` (commanded off), `ST_BLANK` (on, inside the blanking window), `ST_ON` (on, fully protected), `ST_OT_OFF` (shut down by over-temperature) and `ST_PL_OFF` (shut down by power limit). The transitions are as follows:
- A write of 0 takes any state to `ST_OFF`.
- A write of 1 takes `ST_OFF` to `ST_BLANK`. The same write in `ST_BLANK` restarts the window.
- `ST_BLANK` moves to `ST_ON` when the window expires.
- An over-temperature flag takes `ST_BLANK`, `ST_ON` or `ST_PL_OFF` to `ST_OT_OFF`.
- A power-limit flag takes `ST_ON` to `ST_PL_OFF`.
- `ST_OT_OFF` and `ST_PL_OFF` return to `ST_ON` on recovery. They never pass through `ST_BLANK`.

The output enable is high in `ST_BLANK` and `ST_ON`.

Top module: `thermal_guard`

## Requirements
- R1: After reset every output enable is 0, both status registers are 0, the global status byte is 0x00, the global error flag is 0, and every channel is in auto-restart mode.
- R2: A write to address 0x00 sets the enable of each channel whose data bit is 1 and that was off, with the enable visible one cycle after the write. A 0 bit turns the channel off. A 1 bit for a channel that is already on changes nothing. Writes to addresses other than 0x00 and 0x08 have no effect.
- R3: While a channel is not commanded off, an asserted over-temperature flag clears its enable and sets its over-temperature status bit one cycle later. This holds inside the blanking window too.
- R4: While a channel is in `ST_ON`, an asserted power-limit flag clears its enable and sets its power-limit status bit one cycle later.
- R5: For `BLANK_CYCLES` cycles after a switch-on write, the power-limit flag neither sets status nor clears the enable. Another write of 1 during the window restarts the count.
- R6: In auto-restart mode, a channel shut down by over-temperature turns back on one cycle after the reset flag holds and the hot flag is low. Its over-temperature status bit clears on the same edge.
- R7: In auto-restart mode, a channel shut down by power limit turns back on one cycle after the below-threshold flag holds and the above-limit flag is low. Its power-limit status bit clears one cycle later, once the channel is on and the above-limit flag is low.
- R8: In latched mode a shut-down channel stays off while its status bit is set. A read-and-clear clears a bit only if that fault's recovery condition holds at that cycle. The channel turns on one cycle after the bit is clear and recovery holds.
- R9: Read-and-clear at address 0x30 acts only on the over-temperature status register. At address 0x33 it acts only on the power-limit status register.
- R10: Bit 4 of the global status byte and the global error flag both equal the OR of all bits in both status registers. The other bits of the byte are 0.
- R11: Bit n of a write to address 0x08 selects latched mode (1) or auto-restart (0) for channel n, for both fault types.
- R12: A channel that comes back through auto-restart does not start a blanking window, so a power-limit flag in its first on-cycle shuts it down again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ot_hot | input | NCH | Junction above shutdown limit, per channel |
| ot_cool | input | NCH | Junction below over-temperature reset level, per channel |
| dt_high | input | NCH | Temperature difference above power-limit threshold, per channel |
| dt_low | input | NCH | Temperature difference below power-limit reset threshold, per channel |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Register write address (0x00 channel-on, 0x08 restart-mode) |
| wr_data | input | NCH | Register write data, one bit per channel |
| rc_en | input | 1 | Read-and-clear strobe |
| rc_addr | input | 8 | Read-and-clear address (0x30 or 0x33) |
| out_en | output | NCH | Per-channel output enable |
| ot_status | output | NCH | Over-temperature status register |
| pl_status | output | NCH | Power-limit status register |
| gsb | output | 8 | Global status byte, bit 4 is the thermal summary |
| global_err | output | 1 | Global error flag |

## Verification
Assertions check several properties on every cycle. An over-temperature flag on an active channel always leads to a cleared enable with its status bit set. A power-limit flag in `ST_ON` does the same for the power-limit status. The blanking window never lets a power-limit bit rise. A latched channel with its status bit still set never turns on. Auto-restart from over-temperature always brings the channel back with the bit cleared. The window reloads on every start, and the error flag only falls when both registers are empty. Only the bench scenarios can show the rest:
- the exact blanking length and its restart by a second write;
- the one-cycle delayed clearing of a power-limit bit after auto-restart;
- read-and-clear being refused while recovery does not hold;
- the separation of the two read-and-clear addresses;
- the immediate re-trip after an auto-restart that skipped blanking.

// File: rtl/thermal_guard_pkg.sv
package thermal_guard_pkg;

    typedef enum logic [2:0] {
        ST_OFF,
        ST_BLANK,
        ST_ON,
        ST_OT_OFF,
        ST_PL_OFF
    } ch_state_e;

    localparam logic [7:0] ADDR_CHON   = 8'h00;
    localparam logic [7:0] ADDR_MODE   = 8'h08;
    localparam logic [7:0] ADDR_OTSTAT = 8'h30;
    localparam logic [7:0] ADDR_PLSTAT = 8'h33;

    localparam int GSB_THERM_BIT = 4;
    localparam int GSB_WIDTH     = 8;

endpackage

// File: rtl/tg_blank_timer.sv
module tg_blank_timer #(
    parameter int BLANK_CYCLES = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic last
);
    localparam int CW = $clog2(BLANK_CYCLES + 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (start) begin
            cnt <= CW'(BLANK_CYCLES);
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign last = (cnt == CW'(1));

    // R5
    load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (cnt == CW'(BLANK_CYCLES)));

endmodule

// File: rtl/tg_channel.sv
module tg_channel
    import thermal_guard_pkg::*;
#(
    parameter int BLANK_CYCLES = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic on_wr,
    input  logic off_wr,
    input  logic latch_mode,
    input  logic rc_ot,
    input  logic rc_pl,
    input  logic ot_hot,
    input  logic ot_cool,
    input  logic dt_high,
    input  logic dt_low,
    output logic out_en,
    output logic ot_stat,
    output logic pl_stat
);
    ch_state_e st, nxt;
    logic      blank_last;
    logic      blank_start;
    logic      ot_ok, pl_ok;
    logic      ot_set, ot_clr, pl_set, pl_clr;

    assign blank_start = on_wr && (st == ST_OFF || st == ST_BLANK) && !off_wr;

    tg_blank_timer #(.BLANK_CYCLES(BLANK_CYCLES)) u_blank (
        .clk   (clk),
        .rst_n (rst_n),
        .start (blank_start),
        .last  (blank_last)
    );

    assign ot_ok = ot_cool && !ot_hot;
    assign pl_ok = dt_low && !dt_high;

    always_comb begin
        nxt = st;
        if (off_wr) begin
            nxt = ST_OFF;
        end else begin
            unique case (st)
                ST_OFF: begin
                    if (on_wr) nxt = ST_BLANK;
                end
                ST_BLANK: begin
                    if (ot_hot)                     nxt = ST_OT_OFF;
                    else if (blank_last && !on_wr)  nxt = ST_ON;
                end
                ST_ON: begin
                    if (ot_hot)       nxt = ST_OT_OFF;
                    else if (dt_high) nxt = ST_PL_OFF;
                end
                ST_OT_OFF: begin
                    if (ot_ok && (!latch_mode || !ot_stat)) nxt = ST_ON;
                end
                ST_PL_OFF: begin
                    if (ot_hot)                                  nxt = ST_OT_OFF;
                    else if (pl_ok && (!latch_mode || !pl_stat)) nxt = ST_ON;
                end
                default: nxt = ST_OFF;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_OFF;
        else        st <= nxt;
    end

    always_comb begin
        unique case (st)
            ST_BLANK, ST_ON: out_en = 1'b1;
            default:         out_en = 1'b0;
        endcase
    end

    assign ot_set = ot_hot && (st != ST_OFF);
    assign ot_clr = ot_ok && (rc_ot || !latch_mode);
    assign pl_set = (st == ST_ON) && dt_high;
    assign pl_clr = (rc_pl && pl_ok) || (!latch_mode && st == ST_ON && !dt_high);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ot_stat <= 1'b0;
            pl_stat <= 1'b0;
        end else begin
            if (ot_set)      ot_stat <= 1'b1;
            else if (ot_clr) ot_stat <= 1'b0;
            if (pl_set)      pl_stat <= 1'b1;
            else if (pl_clr) pl_stat <= 1'b0;
        end
    end

    // R3
    ot_trip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ot_hot && st != ST_OFF) |=> (!out_en && ot_stat));

    // R4
    pl_trip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_ON && dt_high) |=> (!out_en && pl_stat));

    // R5
    blank_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_BLANK && !pl_stat) |=> !pl_stat);

    // R6
    auto_ot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!latch_mode && st == ST_OT_OFF && ot_ok && !off_wr) |=> (out_en && !ot_stat));

    // R8
    latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (latch_mode && st == ST_OT_OFF && ot_stat) |=> !out_en);

endmodule

// File: rtl/thermal_guard.sv
module thermal_guard
    import thermal_guard_pkg::*;
#(
    parameter int NCH          = 4,
    parameter int BLANK_CYCLES = 64
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NCH-1:0]       ot_hot,
    input  logic [NCH-1:0]       ot_cool,
    input  logic [NCH-1:0]       dt_high,
    input  logic [NCH-1:0]       dt_low,
    input  logic                 wr_en,
    input  logic [7:0]           wr_addr,
    input  logic [NCH-1:0]       wr_data,
    input  logic                 rc_en,
    input  logic [7:0]           rc_addr,
    output logic [NCH-1:0]       out_en,
    output logic [NCH-1:0]       ot_status,
    output logic [NCH-1:0]       pl_status,
    output logic [GSB_WIDTH-1:0] gsb,
    output logic                 global_err
);
    logic [NCH-1:0] mode_q;
    logic           hit_on, hit_mode, hit_ot, hit_pl;
    logic           any_fault;

    assign hit_on   = wr_en && (wr_addr == ADDR_CHON);
    assign hit_mode = wr_en && (wr_addr == ADDR_MODE);
    assign hit_ot   = rc_en && (rc_addr == ADDR_OTSTAT);
    assign hit_pl   = rc_en && (rc_addr == ADDR_PLSTAT);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        mode_q <= '0;
        else if (hit_mode) mode_q <= wr_data;
    end

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        tg_channel #(.BLANK_CYCLES(BLANK_CYCLES)) u_ch (
            .clk        (clk),
            .rst_n      (rst_n),
            .on_wr      (hit_on && wr_data[i]),
            .off_wr     (hit_on && !wr_data[i]),
            .latch_mode (mode_q[i]),
            .rc_ot      (hit_ot),
            .rc_pl      (hit_pl),
            .ot_hot     (ot_hot[i]),
            .ot_cool    (ot_cool[i]),
            .dt_high    (dt_high[i]),
            .dt_low     (dt_low[i]),
            .out_en     (out_en[i]),
            .ot_stat    (ot_status[i]),
            .pl_stat    (pl_status[i])
        );
    end

    assign any_fault = (|ot_status) || (|pl_status);

    always_comb begin
        gsb                = '0;
        gsb[GSB_THERM_BIT] = any_fault;
        global_err         = any_fault;
    end

    // R10
    err_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(global_err) |-> (ot_status == '0 && pl_status == '0));

endmodule

// File: tb/thermal_guard_bench.sv
module thermal_guard_bench;

    localparam int NCH = 4;
    localparam int BLK = 4;

    typedef struct packed {
        logic [3:0] req;
        logic [3:0] hot;
        logic [3:0] cool;
        logic [3:0] dth;
        logic [3:0] dtl;
        logic       wr;
        logic [7:0] waddr;
        logic [3:0] wdata;
        logic       rc;
        logic [7:0] raddr;
        logic [3:0] eo;
        logic [3:0] eot;
        logic [3:0] epl;
    } row_t;

    // Channel 0 and 1 scenario: blanking, power-limit and over-temperature
    // auto-restart (R4 R5 R6 R7 R12), then latched mode and read-and-clear
    // (R8 R9 R11), then channel-on writes and ignored addresses (R2).
    localparam row_t TBL [0:24] = '{
        '{4'd2,  4'h0, 4'hF, 4'h0, 4'hF, 1'b1, 8'h00, 4'h3, 1'b0, 8'h00, 4'h3, 4'h0, 4'h0},
        '{4'd5,  4'h0, 4'hF, 4'h1, 4'hF, 1'b0, 8'h00, 4'h0, 1'b0, 8'h00, 4'h3, 4'h0, 4'h0},
        '{4'd5,  4'h0, 4'hF, 4'h1, 4'hE, 1'b0, 8'h00, 4'h0, 1'b0, 8'h00, 4'h3, 4'h0, 4'h0},
        '{4'd5,  4'h0, 4'hF, 4'h0, 4'hF, 1'b0, 8'h00, 4'h0, 1'b0, 8'h00, 4'h3, 4'h0, 4'h0},
        '{4'd5,  4'h0, 4'hF, 4'h0, 4'hF, 1'b0, 8'h00, 4'h0, 1'b0, 8'h00, 4'h3, 4'h0, 4'h0},
        '{4'd4,  4'h0, 4'hF, 4'h1, 4'hE, 1'b0, 8'h00, 4'h0, 1'b0, 8'h00, 4'h2, 4'h0, 4'h1},
        '{4'd7,  4'h0, 4'hF, 4'h0, 4'hE, 1'b0, 8'h00, 4'h0, 1'b0, 8'h00, 4'h2, 4'h0, 4'h1},
        '{4'd7,  4'h0, 4'hF, 4'h0, 4'hF, 1'b0, 8'h00, 4'h0, 1'b0, 8'h00, 4'h3, 4'h0, 4'h1},
        '{4'd7,  4'h0, 4'hF, 4'h0, 4'hF, 1'b0, 8'h00, 4'h0, 1'b0, 8'h00, 4'h3, 4'h0, 4'h0},
        '{4'd3,  4'h2, 4'hD, 4'h0, 4'hF, 1'b0, 8'h00, 4'h0, 1'b0, 8'h00, 4'h1, 4'h2, 4'h0},
        '{4'd6,  4'h0, 4'hD, 4'h0, 4'hF, 1'b0, 8'h00, 4'h0, 1'b0, 8'h00, 4'h1, 4'h2, 4'h0},
        '{4'd6,  4'h0, 4'hF, 4'h0, 4'hF, 1'b0, 8'h00, 4'h0, 1'b0, 8'h00, 4'h3, 4'h0, 4'h0},
        '{4'd12, 4'h0, 4'hF, 4'h2, 4'hD, 1'b0, 8'h00, 4'h0, 1'b0, 8'h00, 4'h1, 4'h0, 4'h2},
        '{4'd7,  4'h0, 4'hF, 4'h0, 4'hF, 1'b0, 8'h00, 4'h0, 1'b0, 8'h00, 4'h3, 4'h0, 4'h2},
        '{4'd7,  4'h0, 4'hF, 4'h0, 4'hF, 1'b0, 8'h00, 4'h0, 1'b0, 8'h00, 4'h3, 4'h0, 4'h0},
        '{4'd11, 4'h0, 4'hF, 4'h0, 4'hF, 1'b1, 8'h08, 4'h1, 1'b0, 8'h00, 4'h3, 4'h0, 4'h0},
        '{4'd3,  4'h1, 4'hE, 4'h0, 4'hF, 1'b0, 8'h00, 4'h0, 1'b0, 8'h00, 4'h2, 4'h1, 4'h0},
        '{4'd8,  4'h0, 4'hE, 4'h0, 4'hF, 1'b0, 8'h00, 4'h0, 1'b1, 8'h30, 4'h2, 4'h1, 4'h0},
        '{4'd11, 4'h0, 4'hF, 4'h0, 4'hF, 1'b0, 8'h00, 4'h0, 1'b0, 8'h00, 4'h2, 4'h1, 4'h0},
        '{4'd9,  4'h0, 4'hF, 4'h0, 4'hF, 1'b0, 8'h00, 4'h0, 1'b1, 8'h33, 4'h2, 4'h1, 4'h0},
        '{4'd8,  4'h0, 4'hF, 4'h0, 4'hF, 1'b0, 8'h00, 4'h0, 1'b1, 8'h30, 4'h2, 4'h0, 4'h0},
        '{4'd8,  4'h0, 4'hF, 4'h0, 4'hF, 1'b0, 8'h00, 4'h0, 1'b0, 8'h00, 4'h3, 4'h0, 4'h0},
        '{4'd2,  4'h0, 4'hF, 4'h0, 4'hF, 1'b1, 8'h00, 4'h1, 1'b0, 8'h00, 4'h1, 4'h0, 4'h0},
        '{4'd2,  4'h0, 4'hF, 4'h0, 4'hF, 1'b1, 8'h44, 4'hF, 1'b0, 8'h00, 4'h1, 4'h0, 4'h0},
        '{4'd2,  4'h0, 4'hF, 4'h0, 4'hF, 1'b1, 8'h00, 4'h0, 1'b0, 8'h00, 4'h0, 4'h0, 4'h0}
    };

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [NCH-1:0] ot_hot, ot_cool, dt_high, dt_low;
    logic           wr_en, rc_en;
    logic [7:0]     wr_addr, rc_addr;
    logic [NCH-1:0] wr_data;
    logic [NCH-1:0] out_en, ot_status, pl_status;
    logic [7:0]     gsb;
    logic           global_err;

    int checks   = 0;
    int failures = 0;
    int cycles   = 0;
    bit done     = 1'b0;

    always #2 clk = ~clk;

    thermal_guard #(.NCH(NCH), .BLANK_CYCLES(BLK)) u_thermal_guard (
        .clk        (clk),
        .rst_n      (rst_n),
        .ot_hot     (ot_hot),
        .ot_cool    (ot_cool),
        .dt_high    (dt_high),
        .dt_low     (dt_low),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .rc_en      (rc_en),
        .rc_addr    (rc_addr),
        .out_en     (out_en),
        .ot_status  (ot_status),
        .pl_status  (pl_status),
        .gsb        (gsb),
        .global_err (global_err)
    );

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000 && !done) begin
            checks++;
            failures++;
            $display("FAIL watchdog: run hung, actual cycles=%0d expected below 20000", cycles);
            finish_run();
        end
    end

    task automatic drive(input logic [3:0] hot, input logic [3:0] cool,
                         input logic [3:0] dth, input logic [3:0] dtl,
                         input logic wr, input logic [7:0] waddr, input logic [3:0] wdata,
                         input logic rc, input logic [7:0] raddr);
        ot_hot  = hot;
        ot_cool = cool;
        dt_high = dth;
        dt_low  = dtl;
        wr_en   = wr;
        wr_addr = waddr;
        wr_data = wdata;
        rc_en   = rc;
        rc_addr = raddr;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle();
        drive(4'h0, 4'hF, 4'h0, 4'hF, 1'b0, 8'h00, 4'h0, 1'b0, 8'h00);
    endtask

    // Global byte and error flag are checked on every call (R10).
    task automatic chk(input int req, input logic [3:0] eo,
                       input logic [3:0] eot, input logic [3:0] epl);
        logic [7:0] eg;
        logic       ee;
        ee = (eot != 4'h0) || (epl != 4'h0);
        eg = ee ? 8'h10 : 8'h00;
        checks++;
        if (out_en !== eo || ot_status !== eot || pl_status !== epl ||
            gsb !== eg || global_err !== ee) begin
            failures++;
            $display("FAIL R%0d: out=%h ot=%h pl=%h gsb=%h err=%b expected out=%h ot=%h pl=%h gsb=%h err=%b",
                     req, out_en, ot_status, pl_status, gsb, global_err, eo, eot, epl, eg, ee);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        ot_hot = '0; ot_cool = '1; dt_high = '0; dt_low = '1;
        wr_en = 1'b0; wr_addr = '0; wr_data = '0; rc_en = 1'b0; rc_addr = '0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        do_reset();
        chk(1, 4'h0, 4'h0, 4'h0); // R1 reset state

        for (int i = 0; i < 25; i++) begin
            drive(TBL[i].hot, TBL[i].cool, TBL[i].dth, TBL[i].dtl,
                  TBL[i].wr, TBL[i].waddr, TBL[i].wdata, TBL[i].rc, TBL[i].raddr);
            chk(int'(TBL[i].req), TBL[i].eo, TBL[i].eot, TBL[i].epl);
        end

        // R5: second write of 1 during blanking restarts the window
        do_reset();
        drive(4'h0, 4'hF, 4'h0, 4'hF, 1'b1, 8'h00, 4'h4, 1'b0, 8'h00);
        chk(2, 4'h4, 4'h0, 4'h0);
        idle();
        idle();
        drive(4'h0, 4'hF, 4'h0, 4'hF, 1'b1, 8'h00, 4'h4, 1'b0, 8'h00);
        chk(5, 4'h4, 4'h0, 4'h0);
        idle();
        for (int k = 0; k < 3; k++) begin
            drive(4'h0, 4'hF, 4'h4, 4'hB, 1'b0, 8'h00, 4'h0, 1'b0, 8'h00);
            chk(5, 4'h4, 4'h0, 4'h0); // R5 still masked
        end
        drive(4'h0, 4'hF, 4'h4, 4'hB, 1'b0, 8'h00, 4'h0, 1'b0, 8'h00);
        chk(4, 4'h0, 4'h0, 4'h4); // R4 after window

        // R3: over-temperature inside blanking, then R6 auto-restart
        do_reset();
        drive(4'h0, 4'hF, 4'h0, 4'hF, 1'b1, 8'h00, 4'h8, 1'b0, 8'h00);
        chk(2, 4'h8, 4'h0, 4'h0);
        drive(4'h8, 4'h7, 4'h0, 4'hF, 1'b0, 8'h00, 4'h0, 1'b0, 8'h00);
        chk(3, 4'h0, 4'h8, 4'h0);
        drive(4'h0, 4'h7, 4'h0, 4'hF, 1'b0, 8'h00, 4'h0, 1'b0, 8'h00);
        chk(6, 4'h0, 4'h8, 4'h0);
        idle();
        chk(6, 4'h8, 4'h0, 4'h0);

        // R8: latched power-limit recovery, R9 address separation
        do_reset();
        drive(4'h0, 4'hF, 4'h0, 4'hF, 1'b1, 8'h08, 4'h8, 1'b0, 8'h00);
        drive(4'h0, 4'hF, 4'h0, 4'hF, 1'b1, 8'h00, 4'h8, 1'b0, 8'h00);
        chk(11, 4'h8, 4'h0, 4'h0);
        for (int k = 0; k < BLK; k++) idle();
        drive(4'h0, 4'hF, 4'h8, 4'h7, 1'b0, 8'h00, 4'h0, 1'b0, 8'h00);
        chk(4, 4'h0, 4'h0, 4'h8);
        drive(4'h0, 4'hF, 4'h0, 4'h7, 1'b0, 8'h00, 4'h0, 1'b1, 8'h33);
        chk(8, 4'h0, 4'h0, 4'h8); // recovery not yet held
        idle();
        chk(8, 4'h0, 4'h0, 4'h8); // latched: no self recovery
        drive(4'h0, 4'hF, 4'h0, 4'hF, 1'b0, 8'h00, 4'h0, 1'b1, 8'h30);
        chk(9, 4'h0, 4'h0, 4'h8);
        drive(4'h0, 4'hF, 4'h0, 4'hF, 1'b0, 8'h00, 4'h0, 1'b1, 8'h33);
        chk(8, 4'h0, 4'h0, 4'h0);
        idle();
        chk(8, 4'h8, 4'h0, 4'h0);

        finish_run();
    end

endmodule